// File: doc/BRIEF.md
# Missing Clock Edge Detector

This block supervises oscillator clocks. Each channel checks one monitored clock against its own free-running reference clock. The monitored clock is brought into the reference domain through a two-flop synchronizer. A rising edge is found by comparing consecutive synchronized samples. A timeout counter counts reference cycles with no such edge. If the count reaches the configured limit (32 cycles by default), the channel raises a failure output that is meant to drive a system reset request. This output is not an interrupt.

Supervision in a channel runs only while three conditions hold at once: the channel's software enable is set, the oscillator reports that it is running, and the oscillator's stabilization wait has ended. If any of the three drops, the channel is suspended and its counter is cleared. When stabilization completes and the enable is already set, monitoring starts again on its own, with no further software action. After the failure output rises, it stays high until the block reset is applied.

The default build has two independent channels. Channel 0 is meant for a fast monitored clock with a fast reference. Channel 1 is meant for a slow monitored clock with a slow reference. Apart from the shared reset line, nothing links the two channels.

Top module: `mce_monitor`

## Requirements
- R1: With the monitored clock held still, the channel's `fail_req` bit goes high on the 32nd consecutive rising edge of its reference clock at which the channel is active. It is still low after the 31st.
- R2: A monitored clock whose rising edges come every 32 reference cycles never raises `fail_req`. One whose rising edges come every 33 reference cycles raises it.
- R3: While `sup_en` for a channel is 0, that channel never raises `fail_req`, whatever the monitored clock does.
- R4: While `osc_running` for a channel is 0, that channel never raises `fail_req`.
- R5: While `stab_done` for a channel is 0, that channel never raises `fail_req`.
- R6: When `stab_done` rises while `sup_en` and `osc_running` are already 1, monitoring starts with no other input change. A stuck clock then trips `fail_req` on the 32nd reference edge.
- R7: Suspending a channel clears its timeout count. After it resumes, a stuck clock needs a full 32 active reference cycles before `fail_req` rises.
- R8: Once `fail_req` is 1, it stays 1 until reset. Clearing `sup_en` or restarting the monitored clock does not lower it.
- R9: A synchronous active-low `rst_n`, held for several cycles of both reference clocks, drives every `fail_req` bit to 0.
- R10: Channels are independent. Bit 0 of every vector is the fast channel and bit 1 is the slow channel. A failure on one channel leaves the other channel's `fail_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | NUM_CH | Reference clock per channel; each channel's logic runs on its bit |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every reference domain |
| mon_clk | input | NUM_CH | Monitored oscillator clock per channel, asynchronous to the reference |
| sup_en | input | NUM_CH | Software enable per channel, synchronous to that channel's reference |
| osc_running | input | NUM_CH | Oscillator-running flag per channel, synchronous to its reference |
| stab_done | input | NUM_CH | Stabilization-wait-finished flag per channel, synchronous to its reference |
| fail_req | output | NUM_CH | Sticky failure reset request per channel |

## Verification
The bound checker examines every reference cycle of both channels. It confirms that a failure, once raised, stays high until reset, and that reset clears it. It also confirms that a failure only rises after the channel was active on the previous cycle, and only after at least the full timeout of uninterrupted active cycles. The exact trip cycle, the 32-versus-33 cycle period boundary, automatic arming when stabilization ends, clearing of the count during a suspension, and channel independence all depend on the monitored waveform. Only the bench's directed scenarios show these.

// File: rtl/mce_pkg.sv
// Package: shared defaults for the missing clock edge detector.
// Assumes: consumers override these through module parameters where needed.
package mce_pkg;
    localparam int unsigned DEF_NUM_CH      = 2;
    localparam int unsigned DEF_TIMEOUT_CYC = 32;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/mce_edge_sync.sv
// Module: mce_edge_sync
// Brings an asynchronous clock into the reference domain through a flop
// chain, then emits a one-cycle pulse for each rising edge of the
// synchronized sample.
// Assumes: STAGES >= 2; the monitored clock is slower than half the
// reference rate so that each level is sampled at least once.
module mce_edge_sync #(
    parameter int unsigned STAGES = mce_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer chain: stage 0 captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    // Holds the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    // Rising edge seen when the new sample is high and the old one low.
    always_comb begin
        rise_pulse = chain_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/mce_timeout.sv
// Module: mce_timeout
// Counts active reference cycles without an edge pulse. On the LIMIT-th
// such cycle it latches a sticky failure flag, held until reset.
// Assumes: LIMIT >= 1; 'active' and 'edge_seen' are in the clk domain.
module mce_timeout #(
    parameter int unsigned LIMIT = mce_pkg::DEF_TIMEOUT_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic edge_seen,
    output logic tripped
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          trip_q;

    // Timeout counter: cleared by an edge or suspension, frozen once tripped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trip_q) begin
            cnt_q <= cnt_q;
        end else if (!active || edge_seen) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky failure flag: set on the last quiet active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else if (active && !edge_seen && (cnt_q == LAST)) begin
            trip_q <= 1'b1;
        end
    end

    assign tripped = trip_q;
endmodule

// File: rtl/mce_channel.sv
// Module: mce_channel
// One supervision channel: synchronizer, gating of the supervision by
// oscillator state and enable, and the timeout counter.
// Assumes: en, running and stab are synchronous to ref_clk.
module mce_channel #(
    parameter int unsigned LIMIT  = mce_pkg::DEF_TIMEOUT_CYC,
    parameter int unsigned STAGES = mce_pkg::DEF_SYNC_STAGES
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic en,
    input  logic running,
    input  logic stab,
    output logic fail
);
    logic rise;
    logic watch;

    // Supervision is live only while enabled, oscillating and stable.
    always_comb begin
        watch = en & running & stab;
    end

    mce_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .async_in   (mon_clk),
        .rise_pulse (rise)
    );

    mce_timeout #(.LIMIT(LIMIT)) u_tmo (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .active    (watch),
        .edge_seen (rise),
        .tripped   (fail)
    );
endmodule

// File: rtl/mce_monitor.sv
// Module: mce_monitor (top)
// A set of independent missing-clock-edge channels. Each has its own
// reference clock, monitored clock, gating flags and failure output.
// Assumes: rst_n is held for several cycles of every reference clock.
module mce_monitor #(
    parameter int unsigned NUM_CH      = mce_pkg::DEF_NUM_CH,
    parameter int unsigned TIMEOUT_CYC = mce_pkg::DEF_TIMEOUT_CYC,
    parameter int unsigned SYNC_STAGES = mce_pkg::DEF_SYNC_STAGES
) (
    input  logic [NUM_CH-1:0] ref_clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] mon_clk,
    input  logic [NUM_CH-1:0] sup_en,
    input  logic [NUM_CH-1:0] osc_running,
    input  logic [NUM_CH-1:0] stab_done,
    output logic [NUM_CH-1:0] fail_req
);
    // One channel per monitored clock, no shared state between them.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mce_channel #(
            .LIMIT  (TIMEOUT_CYC),
            .STAGES (SYNC_STAGES)
        ) u_ch (
            .ref_clk (ref_clk[g]),
            .rst_n   (rst_n),
            .mon_clk (mon_clk[g]),
            .en      (sup_en[g]),
            .running (osc_running[g]),
            .stab    (stab_done[g]),
            .fail    (fail_req[g])
        );
    end
endmodule

// File: rtl/mce_monitor_chk.sv
// Module: mce_monitor_chk
// Protocol checker bound to mce_monitor. Per channel, it tracks how many
// consecutive active reference cycles have passed and checks the failure
// output against reset, stickiness and the minimum quiet window.
// Assumes: same channel count and timeout as the bound instance.
module mce_monitor_chk #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned LIMIT  = 32
) (
    input logic [NUM_CH-1:0] ref_clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] sup_en,
    input logic [NUM_CH-1:0] osc_running,
    input logic [NUM_CH-1:0] stab_done,
    input logic [NUM_CH-1:0] fail_req
);
    localparam int unsigned RW = $clog2(LIMIT + 1);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic          live;
        logic [RW-1:0] run_q;

        assign live = sup_en[g] & osc_running[g] & stab_done[g];

        // Saturating run length of consecutive active cycles.
        always_ff @(posedge ref_clk[g]) begin
            if (!rst_n || !live) begin
                run_q <= '0;
            end else if (run_q != RW'(LIMIT)) begin
                run_q <= run_q + 1'b1;
            end
        end

        AST_FAIL_STICKY: assert property (@(posedge ref_clk[g]) disable iff (!rst_n)
            fail_req[g] |=> fail_req[g]); // R8
        AST_RESET_CLEARS: assert property (@(posedge ref_clk[g])
            !rst_n |=> !fail_req[g]); // R9
        AST_RISE_AFTER_ACTIVE: assert property (@(posedge ref_clk[g]) disable iff (!rst_n)
            $rose(fail_req[g]) |-> $past(live)); // R4
        AST_NO_EARLY_FAIL: assert property (@(posedge ref_clk[g]) disable iff (!rst_n)
            $rose(fail_req[g]) |-> (run_q >= RW'(LIMIT))); // R1
    end
endmodule

bind mce_monitor mce_monitor_chk #(
    .NUM_CH (NUM_CH),
    .LIMIT  (TIMEOUT_CYC)
) u_chk (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .sup_en      (sup_en),
    .osc_running (osc_running),
    .stab_done   (stab_done),
    .fail_req    (fail_req)
);

// File: tb/mce_monitor_tb.sv
module mce_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW_PERIOD = 3 * CLK_PERIOD;
    localparam int LIMIT = 32;

    logic clk_fast = 1'b0;
    logic clk_slow = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mon = 2'b00;
    logic [1:0] en = 2'b00;
    logic [1:0] run = 2'b00;
    logic [1:0] stab = 2'b00;
    logic [1:0] fail;
    int per [2] = '{0, 0};
    int ph [2] = '{0, 0};
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;
    always #(SLOW_PERIOD/2) clk_slow = ~clk_slow;

    mce_monitor u_dut (
        .ref_clk     ({clk_slow, clk_fast}),
        .rst_n       (rst_n),
        .mon_clk     (mon),
        .sup_en      (en),
        .osc_running (run),
        .stab_done   (stab),
        .fail_req    (fail)
    );

    // Monitored clock generators: rising edge every per[] reference cycles.
    always @(negedge clk_fast) begin
        if (per[0] == 0) begin ph[0] = 0; mon[0] = 1'b0; end
        else begin
            ph[0] = (ph[0] + 1 >= per[0]) ? 0 : ph[0] + 1;
            mon[0] = (ph[0] < per[0] / 2);
        end
    end
    always @(negedge clk_slow) begin
        if (per[1] == 0) begin ph[1] = 0; mon[1] = 1'b0; end
        else begin
            ph[1] = (ph[1] + 1 >= per[1]) ? 0 : ph[1] + 1;
            mon[1] = (ph[1] < per[1] / 2);
        end
    end

    task automatic wait_cyc(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            if (ch == 0) @(negedge clk_fast);
            else @(negedge clk_slow);
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        en = 2'b00; run = 2'b00; stab = 2'b00;
        per[0] = 0; per[1] = 0;
        rst_n = 1'b0;
        wait_cyc(1, 4);
        rst_n = 1'b1;
        wait_cyc(1, 1);
        check("R9 reset fast", fail[0], 1'b0);
        check("R9 reset slow", fail[1], 1'b0);
    endtask

    task automatic arm(input int ch);
        en[ch] = 1'b1; run[ch] = 1'b1; stab[ch] = 1'b1;
    endtask

    // R1 + R10: stuck clock trips exactly on the 32nd active edge.
    task automatic t_stuck(input int ch);
        do_reset();
        wait_cyc(ch, 1);
        arm(ch);
        wait_cyc(ch, LIMIT - 1);
        check("R1 no trip at 31", fail[ch], 1'b0);
        wait_cyc(ch, 1);
        check("R1 trip at 32", fail[ch], 1'b1);
        check("R10 other channel quiet", fail[1-ch], 1'b0);
    endtask

    // R2: period boundary.
    task automatic t_period(input int ch, input int p, input logic exp);
        do_reset();
        per[ch] = p;
        wait_cyc(ch, 3);
        arm(ch);
        wait_cyc(ch, 8 * p);
        check($sformatf("R2 period %0d ch%0d", p, ch), fail[ch], exp);
    endtask

    // R3/R4/R5: one gate low keeps the channel quiet; R6 auto arm on stab.
    task automatic t_gate(input int which);
        do_reset();
        wait_cyc(0, 1);
        arm(0);
        if (which == 0) en[0] = 1'b0;
        else if (which == 1) run[0] = 1'b0;
        else stab[0] = 1'b0;
        wait_cyc(0, 100);
        if (which == 0) check("R3 disabled quiet", fail[0], 1'b0);
        else if (which == 1) check("R4 stopped quiet", fail[0], 1'b0);
        else begin
            check("R5 stabilizing quiet", fail[0], 1'b0);
            stab[0] = 1'b1;
            wait_cyc(0, LIMIT - 1);
            check("R6 auto arm not yet", fail[0], 1'b0);
            wait_cyc(0, 1);
            check("R6 auto arm trips", fail[0], 1'b1);
        end
    endtask

    // R7: suspension clears the count.
    task automatic t_clear();
        do_reset();
        wait_cyc(0, 1);
        arm(0);
        wait_cyc(0, 20);
        run[0] = 1'b0;
        wait_cyc(0, 3);
        run[0] = 1'b1;
        wait_cyc(0, LIMIT - 1);
        check("R7 count cleared", fail[0], 1'b0);
        wait_cyc(0, 1);
        check("R7 full window trips", fail[0], 1'b1);
    endtask

    // R8: sticky through disable and clock recovery; R9 clears it.
    task automatic t_sticky();
        t_stuck(1);
        en[1] = 1'b0;
        per[1] = 4;
        wait_cyc(1, 50);
        check("R8 sticky slow", fail[1], 1'b1);
        rst_n = 1'b0;
        wait_cyc(1, 3);
        check("R9 reset clears trip", fail[1], 1'b0);
        rst_n = 1'b1;
        wait_cyc(1, 1);
    endtask

    // R10: slow channel fails while fast channel is fed and stays low.
    task automatic t_indep();
        do_reset();
        per[0] = 10;
        wait_cyc(0, 3);
        arm(0);
        arm(1);
        wait_cyc(1, 60);
        check("R10 slow trips", fail[1], 1'b1);
        check("R10 fast unaffected", fail[0], 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_stuck(0);
        t_stuck(1);
        t_period(0, 32, 1'b0);
        t_period(0, 33, 1'b1);
        t_period(1, 32, 1'b0);
        t_period(1, 33, 1'b1);
        t_gate(0);
        t_gate(1);
        t_gate(2);
        t_clear();
        t_sticky();
        t_indep();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule